// File: doc/BRIEF.md
# Nibble-prefix instruction decoder

This block turns a stream of one-byte instructions into complete decoded operations. Each byte holds a 4-bit function code in its upper half and a 4-bit data fragment in its lower half. Two function codes are prefixes. A prefix byte folds its fragment into an internal operand accumulator and produces nothing visible. The positive prefix shifts the fragment upward. The negative prefix shifts it upward and inverts it, so the next byte can carry a negative constant. Every other byte completes an instruction. It is issued with its full-width operand, which is the accumulator OR-ed with the byte's own fragment.

The operate code is handled differently. Its built operand is not data: it names a zero-operand extended operation, and the record marks it as such. A small operand, below 16, needs a single byte. Larger or negative operands are built from a chain of prefix bytes.

The block sits between an instruction fetch stage, which offers bytes with a valid/ready handshake, and an execute stage, which receives one record per completed instruction, one cycle after the completing byte is accepted.

Top module: `nibpfx_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is low, and the operand accumulator is cleared, so the first byte after reset issues with its own fragment as the whole operand, even if a prefix preceded the reset.
- R2: in_ready is low while rst is high and high whenever rst is low; a byte is accepted on a rising edge where in_valid and in_ready are both high.
- R3: A non-prefix byte accepted at an edge gives, from that edge until the next, out_valid high, out_fn equal to the byte's bits [7:4], and out_operand equal to accumulator OR zero-extended bits [3:0]; out_valid is high for one cycle per such byte.
- R4: A byte with function code 2 (positive prefix) gives no record, and sets the accumulator to (accumulator OR fragment) shifted left by 4.
- R5: A byte with function code 6 (negative prefix) gives no record, and sets the accumulator to the bitwise inverse of (accumulator OR fragment) shifted left by 4.
- R6: A byte with function code F (operate) issues with out_secondary high and out_sec_code equal to the low SEC_W bits of its operand; for every other issuing code out_secondary is low and out_sec_code is zero.
- R7: The accumulator is cleared whenever a non-prefix byte is issued, so the next instruction starts from its own fragment.
- R8: On a cycle where in_valid is low, no record is produced and the accumulator keeps its value.
- R9: Accumulator bits shifted beyond DATA_W are lost, so an operand built from a long prefix chain keeps only its low DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Instruction byte: function code [7:4], data fragment [3:0] |
| in_valid | input | 1 | in_byte holds a byte to be taken |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| out_valid | output | 1 | A decoded record is present this cycle |
| out_fn | output | 4 | Function code of the issued instruction |
| out_secondary | output | 1 | Record is an extended (operate) operation |
| out_sec_code | output | SEC_W | Extended operation code, zero when not operate |
| out_operand | output | DATA_W | Full operand assembled from prefixes and the final byte |

## Verification
The bench builds the decoder with DATA_W = 16 and SEC_W = 8. The narrow operand lets a chain of five prefix bytes push fragments past the top of the accumulator, so the truncation of R9 is reached. The sign-extended results of negative prefixes show up as short, readable values such as FFF0. The 8-bit extended code is narrower than the operand, so a prefixed operate code that sets bits above the extended field shows that only the low bits reach out_sec_code.

// File: rtl/nibpfx_pkg.sv
package nibpfx_pkg;

    localparam int unsigned NIB_W  = 4;
    localparam int unsigned BYTE_W = 2 * NIB_W;

    // Function code assignment: the two prefix codes and the operate
    // code are decoded by this block; the rest pass through.
    typedef enum logic [NIB_W-1:0] {
        FN_JUMP        = 4'h0,
        FN_LOCAL_PTR   = 4'h1,
        FN_PREFIX      = 4'h2,
        FN_LOAD_IND    = 4'h3,
        FN_LOAD_CONST  = 4'h4,
        FN_IND_PTR     = 4'h5,
        FN_NEG_PREFIX  = 4'h6,
        FN_LOAD_LOCAL  = 4'h7,
        FN_ADD_CONST   = 4'h8,
        FN_CALL        = 4'h9,
        FN_COND_JUMP   = 4'hA,
        FN_ADJ_FRAME   = 4'hB,
        FN_EQ_CONST    = 4'hC,
        FN_STORE_LOCAL = 4'hD,
        FN_STORE_IND   = 4'hE,
        FN_OPERATE     = 4'hF
    } fn_code_e;

    // What an accepted byte does to the accumulator.
    typedef enum logic [1:0] {
        KIND_ISSUE     = 2'd0,
        KIND_SHIFT     = 2'd1,
        KIND_SHIFT_INV = 2'd2
    } byte_kind_e;

    typedef struct packed {
        fn_code_e               fn;
        logic [NIB_W-1:0]       nib;
    } instr_byte_t;

    function automatic byte_kind_e classify(input fn_code_e fn);
        case (fn)
            FN_PREFIX:     return KIND_SHIFT;
            FN_NEG_PREFIX: return KIND_SHIFT_INV;
            default:       return KIND_ISSUE;
        endcase
    endfunction

    function automatic logic is_operate(input fn_code_e fn);
        return fn == FN_OPERATE;
    endfunction

endpackage

// File: rtl/nibpfx_split.sv
module nibpfx_split
    import nibpfx_pkg::*;
(
    input  logic [BYTE_W-1:0] raw,
    output instr_byte_t       fields,
    output byte_kind_e        kind
);
    always_comb begin
        fields = instr_byte_t'(raw);
        kind   = classify(fields.fn);
    end
endmodule

// File: rtl/nibpfx_oreg.sv
module nibpfx_oreg
    import nibpfx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  byte_kind_e        kind,
    input  logic [NIB_W-1:0]  nib,
    output logic [DATA_W-1:0] operand
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_d;

    // Current byte's full operand: accumulated high part plus own fragment.
    assign operand = acc_q | DATA_W'(nib);

    always_comb begin
        acc_d = acc_q;
        if (take) begin
            case (kind)
                KIND_SHIFT:     acc_d = operand << NIB_W;
                KIND_SHIFT_INV: acc_d = (~operand) << NIB_W;
                default:        acc_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end
endmodule

// File: rtl/nibpfx_issue.sv
module nibpfx_issue
    import nibpfx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  byte_kind_e        kind,
    input  fn_code_e          fn,
    input  logic [DATA_W-1:0] operand,
    output logic              rec_valid,
    output logic [NIB_W-1:0]  rec_fn,
    output logic              rec_secondary,
    output logic [SEC_W-1:0]  rec_sec_code,
    output logic [DATA_W-1:0] rec_operand
);
    logic issue;
    logic op_sel;

    assign issue  = take && (kind == KIND_ISSUE);
    assign op_sel = is_operate(fn);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid     <= 1'b0;
            rec_fn        <= '0;
            rec_secondary <= 1'b0;
            rec_sec_code  <= '0;
            rec_operand   <= '0;
        end else begin
            rec_valid <= issue;
            if (issue) begin
                rec_fn        <= fn;
                rec_secondary <= op_sel;
                rec_sec_code  <= op_sel ? operand[SEC_W-1:0] : '0;
                rec_operand   <= operand;
            end
        end
    end
endmodule

// File: rtl/nibpfx_decoder.sv
module nibpfx_decoder
    import nibpfx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              out_valid,
    output logic [3:0]        out_fn,
    output logic              out_secondary,
    output logic [SEC_W-1:0]  out_sec_code,
    output logic [DATA_W-1:0] out_operand
);
    instr_byte_t       fields;
    byte_kind_e        kind;
    logic              take;
    logic [DATA_W-1:0] operand;

    assign in_ready = ~rst;
    assign take     = in_valid && in_ready;

    nibpfx_split u_split (
        .raw    (in_byte),
        .fields (fields),
        .kind   (kind)
    );

    nibpfx_oreg #(.DATA_W(DATA_W)) u_oreg (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .kind    (kind),
        .nib     (fields.nib),
        .operand (operand)
    );

    nibpfx_issue #(.DATA_W(DATA_W), .SEC_W(SEC_W)) u_issue (
        .clk           (clk),
        .rst           (rst),
        .take          (take),
        .kind          (kind),
        .fn            (fields.fn),
        .operand       (operand),
        .rec_valid     (out_valid),
        .rec_fn        (out_fn),
        .rec_secondary (out_secondary),
        .rec_sec_code  (out_sec_code),
        .rec_operand   (out_operand)
    );
endmodule

// File: rtl/nibpfx_decoder_chk.sv
module nibpfx_decoder_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEC_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        in_byte,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [3:0]        out_fn,
    input logic              out_secondary,
    input logic [SEC_W-1:0]  out_sec_code,
    input logic [DATA_W-1:0] out_operand
);
    logic acc_any;
    logic acc_issue;
    logic acc_pfx;

    assign acc_any   = in_valid && in_ready;
    assign acc_pfx   = acc_any && (in_byte[7:4] == 4'h2 || in_byte[7:4] == 4'h6);
    assign acc_issue = acc_any && !(in_byte[7:4] == 4'h2 || in_byte[7:4] == 4'h6);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

    a_r2_ready_when_running: assert property (@(posedge clk) disable iff (rst)
        in_ready);

    a_r3_issue_gives_record: assert property (@(posedge clk) disable iff (rst)
        acc_issue |=> out_valid && out_fn == $past(in_byte[7:4]));

    a_r4_r5_prefix_silent: assert property (@(posedge clk) disable iff (rst)
        acc_pfx |=> !out_valid);

    a_r6_flag_matches_code: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_secondary == (out_fn == 4'hF)));

    a_r6_no_code_unless_operate: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_secondary) |-> out_sec_code == '0);

    a_r7_fresh_after_issue: assert property (@(posedge clk) disable iff (rst)
        (acc_issue && $past(acc_issue)) |=> out_operand == DATA_W'($past(in_byte[3:0])));

    a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !acc_any |=> !out_valid);
endmodule

bind nibpfx_decoder nibpfx_decoder_chk #(.DATA_W(DATA_W), .SEC_W(SEC_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .in_byte       (in_byte),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_fn        (out_fn),
    .out_secondary (out_secondary),
    .out_sec_code  (out_sec_code),
    .out_operand   (out_operand)
);

// File: tb/test_nibpfx_decoder.sv
`timescale 1ns/1ps
module test_nibpfx_decoder;
    localparam int unsigned DW = 16;
    localparam int unsigned SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    in_byte = 8'h00;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          out_valid;
    logic [3:0]    out_fn;
    logic          out_secondary;
    logic [SW-1:0] out_sec_code;
    logic [DW-1:0] out_operand;

    int n_chk  = 0;
    int n_fail = 0;
    logic [DW-1:0] m_acc = '0;

    always #5 clk = ~clk;

    nibpfx_decoder #(.DATA_W(DW), .SEC_W(SW)) i_nibpfx_decoder (
        .clk           (clk),
        .rst           (rst),
        .in_byte       (in_byte),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .out_valid     (out_valid),
        .out_fn        (out_fn),
        .out_secondary (out_secondary),
        .out_sec_code  (out_sec_code),
        .out_operand   (out_operand)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one byte for one cycle at a falling edge, then check the
    // record registered on the rising edge in between.
    task automatic push(input logic [7:0] b, input string tag);
        logic [DW-1:0] opnd;
        opnd = m_acc | DW'(b[3:0]);
        in_byte  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (b[7:4] == 4'h2) begin
            m_acc = opnd << 4;
            chk({tag, " R4 prefix no record"}, out_valid, 0);
        end else if (b[7:4] == 4'h6) begin
            m_acc = (~opnd) << 4;
            chk({tag, " R5 neg prefix no record"}, out_valid, 0);
        end else begin
            chk({tag, " R3 valid"}, out_valid, 1);
            chk({tag, " R3 fn"}, out_fn, b[7:4]);
            chk({tag, " R3 operand"}, out_operand, opnd);
            chk({tag, " R6 flag"}, out_secondary, (b[7:4] == 4'hF));
            chk({tag, " R6 code"}, out_sec_code, (b[7:4] == 4'hF) ? opnd[SW-1:0] : '0);
            m_acc = '0;
        end
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        chk({tag, " R8 idle no record"}, out_valid, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 ready low in reset", in_ready, 0);
        chk("R1 valid low in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid low after reset", out_valid, 0);
        chk("R2 ready high after reset", in_ready, 1);
        m_acc = '0;
    endtask

    task automatic t_single_bytes;
        for (int c = 0; c < 16; c++) begin
            if (c != 2 && c != 6) push({c[3:0], 4'(15 - c)}, "single");
        end
        idle("R3 one-cycle pulse");
    endtask

    task automatic t_prefix;
        push(8'h21, "pfx");
        push(8'h42, "pfx");
        chk("R4 prefixed operand 0x12", out_operand, 16'h0012);
        push(8'h2A, "pfx2");
        push(8'h2B, "pfx2");
        push(8'h9C, "pfx2");
        chk("R4 three-byte operand 0xABC", out_operand, 16'h0ABC);
    endtask

    task automatic t_negative;
        push(8'h60, "neg");
        push(8'h40, "neg");
        chk("R5 neg 0 gives FFF0", out_operand, 16'hFFF0);
        push(8'h60, "neg");
        push(8'h4F, "neg");
        chk("R5 neg then F gives FFFF", out_operand, 16'hFFFF);
        push(8'h21, "mix");
        push(8'h65, "mix");
        push(8'h83, "mix");
        chk("R5 mixed chain FEA3", out_operand, 16'hFEA3);
    endtask

    task automatic t_operate;
        push(8'hF5, "opr");
        chk("R6 operate code 5", out_sec_code, 8'h05);
        push(8'h21, "opr");
        push(8'hF3, "opr");
        chk("R6 prefixed operate 0x13", out_sec_code, 8'h13);
        push(8'h21, "oprw");
        push(8'h22, "oprw");
        push(8'hF3, "oprw");
        chk("R6 operate code low bits 0x23", out_sec_code, 8'h23);
        chk("R6 operate operand 0x123", out_operand, 16'h0123);
        push(8'h47, "after opr");
        chk("R6 flag clears", out_secondary, 0);
    endtask

    task automatic t_clear;
        push(8'h2F, "clr");
        push(8'h43, "clr");
        push(8'h47, "clr");
        chk("R7 cleared after issue", out_operand, 16'h0007);
    endtask

    task automatic t_idle;
        push(8'h23, "gap");
        idle("gap1");
        idle("gap2");
        push(8'h41, "gap");
        chk("R8 accumulator held across idle", out_operand, 16'h0031);
    endtask

    task automatic t_overflow;
        push(8'h21, "ovf");
        push(8'h22, "ovf");
        push(8'h23, "ovf");
        push(8'h24, "ovf");
        push(8'h25, "ovf");
        push(8'h46, "ovf");
        chk("R9 truncated to low bits", out_operand, 16'h3456);
    endtask

    task automatic t_reset_mid;
        push(8'h27, "pre-reset");
        rst = 1'b1;
        @(negedge clk);
        chk("R2 ready low on mid reset", in_ready, 0);
        rst = 1'b0;
        m_acc = '0;
        @(negedge clk);
        chk("R1 no record after mid reset", out_valid, 0);
        push(8'h41, "post-reset");
        chk("R1 accumulator cleared by reset", out_operand, 16'h0001);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single_bytes();
        t_prefix();
        t_negative();
        t_operate();
        t_clear();
        t_idle();
        t_overflow();
        t_reset_mid();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule